// File: doc/BRIEF.md
# Conversion Result Buffer with Temperature Slot

This block sits between a 10-bit converter core and a serial readout port. It keeps up to sixteen voltage results in arrival order and holds, apart from them, a single temperature result. Each result is packed into a 16-bit word and leaves the block one byte at a time, high byte first, through a valid/ready read interface.

The write side is a plain strobe that the block always accepts. No back-pressure is applied. When the voltage queue is full, a new voltage result pushes out the oldest one. The read side presents a byte on `rd_data` together with `rd_valid`. A byte is consumed in any cycle where both `rd_valid` and `rd_ready` are high. When nothing is stored, `rd_valid` is low, `rd_data` reads zero and `rd_ready` has no effect.

A falling edge of chip select, given as a one-cycle pulse, rewinds the read to the high byte of the oldest word. A synchronous flush empties both storage places.

Top module: `cres_fifo_top`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 8'h00.
- R2: A result is packed as {4'b0000, result[9:0], sub[1:0]}. The high byte (bits 15:8) is presented before the low byte (bits 7:0).
- R3: Voltage words leave in arrival order. A word is retired only after its low byte is consumed.
- R4: The voltage queue holds 16 words. When a voltage write arrives while the queue is full and no word is retired in that cycle, the oldest word is discarded and the count stays at 16.
- R5: At a word boundary, a valid temperature word is presented before any voltage word.
- R6: The temperature slot holds one word, and a new temperature write replaces an unread one. The slot empties after its low byte is consumed. If the word being read is replaced half-way through, reading restarts at the high byte of the new word.
- R7: A `cs_fall` pulse returns the read position to the high byte of the oldest available word. A pop requested in that same cycle is ignored.
- R8: With both the queue and the slot empty, `rd_data` is 8'h00, `rd_valid` is 0, and `rd_ready` changes nothing.
- R9: `flush` empties the queue and the slot in one cycle, so `rd_valid` is 0 in the next cycle. Flush takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all stored results |
| cs_fall | input | 1 | One-cycle pulse marking a chip-select falling edge |
| wr_valid | input | 1 | Result write strobe (always accepted) |
| wr_result | input | 10 | Converter result |
| wr_sub | input | 2 | Sub-LSB bits |
| wr_is_temp | input | 1 | 1 = temperature result, 0 = voltage result |
| rd_ready | input | 1 | Consumer takes the presented byte |
| rd_valid | output | 1 | A stored byte is presented |
| rd_data | output | 8 | Presented byte, zero when empty |

## Verification
The assertions assume that `cs_fall` is a single-cycle pulse. They also assume that `rd_ready` is only a request, so a pop needs `rd_valid` too, and that a retire from the read side happens only while a word is stored. The stimulus drives every input at the falling clock edge. It raises `cs_fall` and `flush` for exactly one cycle. It never pairs a write with a pop in one cycle, except in cases whose outcome the requirements define. This keeps the reference model in the bench free of same-cycle ordering questions.

// File: rtl/cres_pkg.sv
package cres_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  function automatic logic [WORD_W-1:0] pack_word(input logic [9:0] res, input logic [1:0] sub);
    return {{(WORD_W-12){1'b0}}, res, sub};
  endfunction
endpackage

// File: rtl/cres_vqueue.sv
module cres_vqueue #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              retire,
  output logic [WORD_W-1:0] head_word,
  output logic              nonempty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail, head_inc, tail_inc;
  logic [CW-1:0] count;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign head_inc = head + 1'b1;
      assign tail_inc = tail + 1'b1;
    end else begin : g_wrap
      assign head_inc = (head == LAST) ? '0 : head + 1'b1;
      assign tail_inc = (tail == LAST) ? '0 : tail + 1'b1;
    end
  endgenerate

  assign nonempty  = (count != '0);
  assign full      = (count == CFULL);
  assign head_word = mem[head];

  logic do_ret, head_adv;
  assign do_ret   = retire & nonempty;
  assign head_adv = do_ret | (push & full);

  always_ff @(posedge clk) begin
    if (push && !flush) mem[tail] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; count <= '0;
    end else if (flush) begin
      head <= '0; tail <= '0; count <= '0;
    end else begin
      if (push) tail <= tail_inc;
      if (head_adv) head <= head_inc;
      if (push && !do_ret && !full) count <= count + 1'b1;
      else if (do_ret && !push) count <= count - 1'b1;
    end
  end

  // R4
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !retire && !flush) |=> full);

  // R3
  push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |=> nonempty);
endmodule

// File: rtl/cres_tslot.sv
module cres_tslot #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              clr,
  output logic              valid,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; word <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (wr) begin
      valid <= 1'b1; word <= wr_word;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cres_bytesel.sv
module cres_bytesel #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cs_fall,
  input  logic              rd_ready,
  input  logic              t_valid,
  input  logic [WORD_W-1:0] t_word,
  input  logic              t_write,
  input  logic              v_nonempty,
  input  logic [WORD_W-1:0] v_word,
  input  logic              v_drop,
  output logic              rd_valid,
  output logic [WORD_W/2-1:0] rd_data,
  output logic              t_clr,
  output logic              v_retire
);
  localparam int HW = WORD_W / 2;

  logic ptr, lock_t, cur_t, pop, clobber, ret;
  logic [WORD_W-1:0] word;

  assign cur_t    = ptr ? lock_t : t_valid;
  assign rd_valid = cur_t ? t_valid : v_nonempty;
  assign word     = cur_t ? t_word : v_word;
  assign rd_data  = rd_valid ? (ptr ? word[HW-1:0] : word[WORD_W-1:HW]) : '0;
  assign pop      = rd_valid & rd_ready & ~cs_fall & ~flush;
  assign clobber  = cur_t ? t_write : v_drop;
  assign ret      = pop & ptr;
  assign t_clr    = ret & cur_t;
  assign v_retire = ret & ~cur_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= 1'b0; lock_t <= 1'b0;
    end else if (flush || cs_fall || clobber) begin
      ptr <= 1'b0;
    end else if (pop) begin
      ptr <= ~ptr;
      if (!ptr) lock_t <= cur_t;
    end
  end
endmodule

// File: rtl/cres_fifo_top.sv
module cres_fifo_top #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       cs_fall,
  input  logic       wr_valid,
  input  logic [9:0] wr_result,
  input  logic [1:0] wr_sub,
  input  logic       wr_is_temp,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  import cres_pkg::*;

  logic [WORD_W-1:0] in_word, t_word, v_word;
  logic t_write, v_push, t_valid, t_clr, v_nonempty, v_full, v_retire, v_drop;

  assign in_word = pack_word(wr_result, wr_sub);
  assign t_write = wr_valid & wr_is_temp & ~flush;
  assign v_push  = wr_valid & ~wr_is_temp & ~flush;
  assign v_drop  = v_push & v_full & ~v_retire;

  cres_vqueue #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_vq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(v_push), .push_word(in_word),
    .retire(v_retire), .head_word(v_word), .nonempty(v_nonempty), .full(v_full));

  cres_tslot #(.WORD_W(WORD_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr(t_write), .wr_word(in_word),
    .clr(t_clr), .valid(t_valid), .word(t_word));

  cres_bytesel #(.WORD_W(WORD_W)) u_bs (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cs_fall(cs_fall), .rd_ready(rd_ready),
    .t_valid(t_valid), .t_word(t_word), .t_write(t_write), .v_nonempty(v_nonempty),
    .v_word(v_word), .v_drop(v_drop), .rd_valid(rd_valid), .rd_data(rd_data),
    .t_clr(t_clr), .v_retire(v_retire));

  // R5
  temp_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_is_temp && !flush) |=> rd_valid);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_valid);
endmodule

// File: tb/sim_cres_fifo_top.sv
module sim_cres_fifo_top;
  logic clk = 0, rst_n = 0, flush = 0, cs_fall = 0, wr_valid = 0, wr_is_temp = 0, rd_ready = 0;
  logic [9:0] wr_result = '0;
  logic [1:0] wr_sub = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  cres_fifo_top u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .cs_fall(cs_fall),
    .wr_valid(wr_valid), .wr_result(wr_result), .wr_sub(wr_sub), .wr_is_temp(wr_is_temp),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data));

  always #4 clk = ~clk;

  // reference model (scoreboard state)
  logic [15:0] mq[$];
  logic [15:0] mt = '0;
  bit mtv = 0, mptr = 0, mlock = 0;

  function automatic bit cur_t(); return mptr ? mlock : mtv; endfunction
  function automatic bit exp_valid(); return cur_t() ? mtv : (mq.size() > 0); endfunction
  function automatic logic [7:0] exp_byte();
    logic [15:0] w;
    if (!exp_valid()) return 8'h00;
    w = cur_t() ? mt : mq[0];
    return mptr ? w[7:0] : w[15:8];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [9:0] r, logic [1:0] s, bit t);
    @(negedge clk); wr_valid = 1; wr_result = r; wr_sub = s; wr_is_temp = t;
    @(posedge clk);
    if (t) begin
      if (cur_t()) mptr = 0;
      mt = {4'b0, r, s}; mtv = 1;
    end else begin
      if (mq.size() == 16) begin void'(mq.pop_front()); if (!cur_t()) mptr = 0; end
      mq.push_back({4'b0, r, s});
    end
    @(negedge clk); wr_valid = 0; wr_is_temp = 0;
  endtask

  // monitor side: compare presented byte with the scoreboard, then consume it
  task automatic do_pop(string req);
    bit ct;
    @(negedge clk);
    chk(req, {7'b0, rd_valid}, {7'b0, exp_valid()});
    chk(req, rd_data, exp_byte());
    rd_ready = 1;
    @(posedge clk);
    ct = cur_t();
    if (exp_valid()) begin
      if (mptr) begin
        if (ct) mtv = 0; else void'(mq.pop_front());
        mptr = 0;
      end else begin
        mlock = ct; mptr = 1;
      end
    end
    @(negedge clk); rd_ready = 0;
  endtask

  task automatic pulse_cs(bit with_pop);
    @(negedge clk); cs_fall = 1; rd_ready = with_pop;
    @(posedge clk); mptr = 0;
    @(negedge clk); cs_fall = 0; rd_ready = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1; wr_valid = 1; wr_is_temp = 1; wr_result = 10'h111;
    @(posedge clk); mq.delete(); mtv = 0; mptr = 0;
    @(negedge clk); flush = 0; wr_valid = 0; wr_is_temp = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {7'b0, rd_valid}, 8'h00);
    chk("R1", rd_data, 8'h00);

    // R2 packing: 0x2A5 / sub 3 -> 0x0A then 0x97
    do_write(10'h2A5, 2'b11, 0);
    @(negedge clk); chk("R2", rd_data, 8'h0A);
    do_pop("R2");
    @(negedge clk); chk("R2", rd_data, 8'h97);
    do_pop("R2");

    // R8 empty: zero output, pop ignored
    do_pop("R8");
    do_pop("R8");

    // R3 ordering
    for (int i = 0; i < 5; i++) do_write(10'(i * 91 + 7), 2'(i), 0);
    for (int i = 0; i < 10; i++) do_pop("R3");

    // R4 overflow: 18 writes, first two dropped
    for (int i = 0; i < 18; i++) do_write(10'(i * 37 + 5), 2'(i), 0);
    @(negedge clk); chk("R4", rd_data, 8'(({4'b0, 10'(2 * 37 + 5), 2'd2}) >> 8));
    for (int i = 0; i < 32; i++) do_pop("R4");
    do_pop("R8");

    // R5 temperature first at word boundary
    for (int i = 0; i < 3; i++) do_write(10'(i + 100), 2'd1, 0);
    do_pop("R5");
    do_write(10'h3C1, 2'd2, 1);
    do_pop("R5");
    @(negedge clk); chk("R5", rd_data, 8'h0F);
    for (int i = 0; i < 6; i++) do_pop("R5");

    // R6 overwrite of unread temperature, and replacement mid-read
    do_write(10'h155, 2'd0, 1);
    do_write(10'h0AA, 2'd3, 1);
    do_pop("R6");
    do_write(10'h2F0, 2'd1, 1);
    @(negedge clk); chk("R6", rd_data, 8'h0B);
    do_pop("R6");
    do_pop("R6");
    do_pop("R6");

    // R7 chip-select rewind, with and without a same-cycle pop
    do_write(10'h1E3, 2'd2, 0);
    do_pop("R7");
    pulse_cs(0);
    @(negedge clk); chk("R7", rd_data, 8'h07);
    do_pop("R7");
    pulse_cs(1);
    @(negedge clk); chk("R7", rd_data, 8'h07);
    do_pop("R7");
    do_pop("R7");

    // R9 flush wins over a same-cycle write
    do_write(10'h011, 2'd0, 0);
    do_write(10'h022, 2'd0, 1);
    do_flush();
    do_pop("R9");
    @(negedge clk); chk("R9", rd_data, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule